// File: doc/BRIEF.md
# Timer-Paced Dual-Lane Serial Converter Reader

This block is the master side of a link to a simultaneous-sampling serial converter that drives two data lines. A free-running divider makes a serial clock from the system clock. An interval timer counts whole serial-clock periods and asks for a new frame each time it expires. Every frame is opened by pulling an active-low select line, and it is always aligned to the serial-clock phase. Because of this, the distance between frame starts is always a whole number of serial-clock periods, and sampling stays equidistant.

Within one frame both data lines are shifted in together, most significant bit first, on falling serial-clock edges. When the frame closes, both words are written right-justified into their own result registers, and a single-cycle valid strobe is raised. A short 14-clock word can be selected. A power-down request turns the next frame into an 8-clock burst that delivers no data. A timer expiry that comes while a frame is pending or running is dropped and raises a sticky overrun flag.

Top module: `dual_adc_reader`

## Requirements
- R1: After synchronous reset, and whenever no frame is open, cs_n and sclk are both high. After reset, res_a, res_b, res_valid and overrun are all 0.
- R2: Inside a frame, sclk has a period of 2*(cfg_div+1) system clocks. A frame opens while sclk is high, and the first falling edge of sclk comes cfg_div+1 cycles after cs_n falls.
- R3: While enable is high, frame starts repeat every cfg_interval serial-clock periods (cfg_interval*2*(cfg_div+1) system clocks), provided no tick is dropped.
- R4: With short_word low, a data frame has 16 falling sclk edges, and cs_n stays low for exactly 16 serial-clock periods.
- R5: With short_word high at frame start, the frame has 14 falling sclk edges, and cs_n stays low for exactly 14 periods.
- R6: Both lanes are sampled on each falling sclk edge of the same frame, MSB first. A frame of L clocks leaves the L received bits in the low bits of res_a and res_b (din_a and din_b respectively), and the upper bits are zero.
- R7: res_valid is a one-cycle pulse in the first cycle that cs_n is high again after a data frame. res_a and res_b change only in that cycle.
- R8: A one-cycle pulse on pd_req turns the next frame into a burst of 8 falling sclk edges (cs_n low for 8 periods). That frame raises no res_valid and leaves res_a and res_b unchanged. Later frames are normal data frames again.
- R9: A timer tick that arrives while a frame is pending or open, including its closing edge, is ignored and sets overrun, which stays set until reset. For 16-clock words, cfg_interval = 17 sets overrun and spaces starts 34 periods apart, while cfg_interval = 18 leaves overrun clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| enable | input | 1 | Runs the interval timer when high |
| cfg_div | input | DIV_W | Serial clock half-period minus one, in system clocks |
| cfg_interval | input | TMR_W | Frame interval in serial-clock periods (0 is treated as 1) |
| short_word | input | 1 | Selects 14-clock words |
| pd_req | input | 1 | Pulse: next frame is an 8-clock power-down burst |
| din_a | input | 1 | Serial data, lane A |
| din_b | input | 1 | Serial data, lane B |
| sclk | output | 1 | Serial clock, idles high |
| cs_n | output | 1 | Active-low frame select |
| res_a | output | DATA_W | Right-justified lane A result |
| res_b | output | DATA_W | Right-justified lane B result |
| res_valid | output | 1 | One-cycle strobe when both results are updated |
| overrun | output | 1 | Sticky flag for a dropped tick |

## Verification
All timing is measured from the fall of cs_n. The first sclk fall is due cfg_div+1 cycles later. cs_n rises after L periods of 2*(cfg_div+1) cycles, and in that same cycle the results and res_valid are due. The next fall of cs_n is due cfg_interval periods after the previous one. The bench samples on the falling system-clock edge and stamps every cs_n and sclk transition with a cycle counter. Each of these distances is then compared with the value computed from the configuration, and the data and strobe are compared in the exact cycle cs_n rises.

// File: rtl/adcr_pkg.sv
package adcr_pkg;

  typedef enum logic [1:0] {
    SY_IDLE  = 2'd0,
    SY_ARMED = 2'd1,
    SY_LOW   = 2'd2,
    SY_RUN   = 2'd3
  } sync_state_t;

  localparam int BURST_LEN = 8;
  localparam int SHORT_TRIM = 2;

  // Number of serial clocks in a frame for the given mode.
  function automatic int frame_len(input logic burst, input logic short_w, input int full_len);
    if (burst)
      return BURST_LEN;
    else if (short_w)
      return full_len - SHORT_TRIM;
    else
      return full_len;
  endfunction

  // Timer compare value: an interval of zero behaves as one period.
  function automatic int unsigned timer_limit(input int unsigned interval);
    return (interval == 0) ? 0 : interval - 1;
  endfunction

endpackage

// File: rtl/adcr_sclk_gen.sv
module adcr_sclk_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div,
  output logic             ph,
  output logic             rise_ev,
  output logic             fall_ev
);
  logic [DIV_W-1:0] cnt_q;
  logic             ph_q;
  logic             wrap;

  assign wrap    = (cnt_q >= div);
  assign rise_ev = wrap & ~ph_q;
  assign fall_ev = wrap & ph_q;
  assign ph      = ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else if (wrap) begin
      cnt_q <= '0;
      ph_q  <= ~ph_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adcr_interval_timer.sv
module adcr_interval_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             rise_ev,
  input  logic [TMR_W-1:0] interval,
  output logic             tick
);
  logic [TMR_W-1:0] tcnt_q;
  logic [TMR_W-1:0] lim;
  logic             hit;

  assign lim  = TMR_W'(adcr_pkg::timer_limit(32'(interval)));
  assign hit  = (tcnt_q >= lim);
  assign tick = enable & rise_ev & hit;

  always_ff @(posedge clk) begin
    if (rst || !enable)
      tcnt_q <= '0;
    else if (rise_ev)
      tcnt_q <= hit ? '0 : tcnt_q + 1'b1;
  end
endmodule

// File: rtl/adcr_frame_ctrl.sv
module adcr_frame_ctrl
  import adcr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic rise_ev,
  input  logic fall_ev,
  input  logic short_word,
  input  logic pd_req,
  output logic cs_n,
  output logic start_ev,
  output logic shift_ev,
  output logic load_ev,
  output logic valid,
  output logic overrun
);
  localparam int BCW = $clog2(DATA_W + 1);

  sync_state_t      state_q, state_d;
  logic [BCW-1:0]   bitcnt_q;
  logic [BCW-1:0]   len_q;
  logic [BCW-1:0]   len_d;
  logic             burst_q;
  logic             pd_pend_q;
  logic             cs_n_q;
  logic             valid_q;
  logic             overrun_q;
  logic             fin_ev;

  assign len_d    = BCW'(frame_len(pd_pend_q, short_word, DATA_W));
  assign start_ev = (state_q == SY_LOW) & rise_ev;
  assign fin_ev   = (state_q == SY_RUN) & rise_ev & (bitcnt_q == len_q);
  assign shift_ev = (state_q == SY_RUN) & fall_ev & (bitcnt_q != len_q);
  assign load_ev  = fin_ev & ~burst_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      SY_IDLE:  if (tick)    state_d = SY_ARMED;
      SY_ARMED: if (fall_ev) state_d = SY_LOW;
      SY_LOW:   if (rise_ev) state_d = SY_RUN;
      SY_RUN:   if (fin_ev)  state_d = SY_IDLE;
      default:               state_d = SY_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SY_IDLE;
      bitcnt_q  <= '0;
      len_q     <= '0;
      burst_q   <= 1'b0;
      pd_pend_q <= 1'b0;
      cs_n_q    <= 1'b1;
      valid_q   <= 1'b0;
      overrun_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= load_ev;
      if (tick && state_q != SY_IDLE)
        overrun_q <= 1'b1;
      if (start_ev)
        pd_pend_q <= pd_req;
      else if (pd_req)
        pd_pend_q <= 1'b1;
      if (start_ev) begin
        cs_n_q   <= 1'b0;
        bitcnt_q <= '0;
        len_q    <= len_d;
        burst_q  <= pd_pend_q;
      end else if (fin_ev) begin
        cs_n_q <= 1'b1;
      end else if (shift_ev) begin
        bitcnt_q <= bitcnt_q + 1'b1;
      end
    end
  end

  assign cs_n    = cs_n_q;
  assign valid   = valid_q;
  assign overrun = overrun_q;
endmodule

// File: rtl/adcr_lane_shift.sv
module adcr_lane_shift #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              shift,
  input  logic              load,
  input  logic              din,
  output logic [DATA_W-1:0] res
);
  logic [DATA_W-1:0] sr_q;
  logic [DATA_W-1:0] res_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q  <= '0;
      res_q <= '0;
    end else begin
      if (clear)
        sr_q <= '0;
      else if (shift)
        sr_q <= {sr_q[DATA_W-2:0], din};
      if (load)
        res_q <= sr_q;
    end
  end

  assign res = res_q;
endmodule

// File: rtl/dual_adc_reader.sv
module dual_adc_reader #(
  parameter int DIV_W  = 8,
  parameter int TMR_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [TMR_W-1:0]  cfg_interval,
  input  logic              short_word,
  input  logic              pd_req,
  input  logic              din_a,
  input  logic              din_b,
  output logic              sclk,
  output logic              cs_n,
  output logic [DATA_W-1:0] res_a,
  output logic [DATA_W-1:0] res_b,
  output logic              res_valid,
  output logic              overrun
);
  localparam int LANES = 2;

  logic ph_w;
  logic rise_w;
  logic fall_w;
  logic tick_w;
  logic start_w;
  logic shift_w;
  logic load_w;
  logic cs_n_w;

  logic [LANES-1:0]  din_vec;
  logic [DATA_W-1:0] res_arr [LANES];

  adcr_sclk_gen #(.DIV_W(DIV_W)) u_sclk (
    .clk(clk), .rst(rst), .div(cfg_div),
    .ph(ph_w), .rise_ev(rise_w), .fall_ev(fall_w)
  );

  adcr_interval_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst(rst), .enable(enable), .rise_ev(rise_w),
    .interval(cfg_interval), .tick(tick_w)
  );

  adcr_frame_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick_w), .rise_ev(rise_w), .fall_ev(fall_w),
    .short_word(short_word), .pd_req(pd_req), .cs_n(cs_n_w),
    .start_ev(start_w), .shift_ev(shift_w), .load_ev(load_w),
    .valid(res_valid), .overrun(overrun)
  );

  assign din_vec = {din_b, din_a};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    adcr_lane_shift #(.DATA_W(DATA_W)) u_lane (
      .clk(clk), .rst(rst), .clear(start_w), .shift(shift_w),
      .load(load_w), .din(din_vec[g]), .res(res_arr[g])
    );
  end

  assign res_a = res_arr[0];
  assign res_b = res_arr[1];
  assign cs_n  = cs_n_w;
  assign sclk  = cs_n_w | ph_w;
endmodule

// File: rtl/dual_adc_reader_chk.sv
module dual_adc_reader_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              sclk,
  input logic              cs_n,
  input logic              shift_w,
  input logic [DATA_W-1:0] res_a,
  input logic [DATA_W-1:0] res_b,
  input logic              res_valid,
  input logic              overrun
);
  localparam int BCW = $clog2(DATA_W + 1);

  logic [BCW-1:0] fc_q;

  always_ff @(posedge clk) begin
    if (rst || cs_n)
      fc_q <= '0;
    else if (shift_w)
      fc_q <= fc_q + 1'b1;
  end

  assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> sclk);

  assert_open_on_high_R2: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> sclk);

  assert_shift_in_frame_R6: assert property (@(posedge clk) disable iff (rst)
    shift_w |-> !cs_n);

  assert_frame_len_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> (fc_q == BCW'(DATA_W) || fc_q == BCW'(DATA_W - 2) || fc_q == BCW'(8)));

  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  assert_valid_at_close_R7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> $rose(cs_n));

  assert_results_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (!$stable(res_a) || !$stable(res_b)) |-> res_valid);

  assert_burst_no_valid_R8: assert property (@(posedge clk) disable iff (rst)
    ($rose(cs_n) && fc_q == BCW'(8)) |-> !res_valid);

  assert_overrun_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);
endmodule

bind dual_adc_reader dual_adc_reader_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .shift_w(shift_w),
  .res_a(res_a), .res_b(res_b), .res_valid(res_valid), .overrun(overrun)
);

// File: tb/tb_dual_adc_reader.sv
module tb_dual_adc_reader;
  localparam int DIV_W  = 8;
  localparam int TMR_W  = 16;
  localparam int DATA_W = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0;
  logic [DIV_W-1:0] cfg_div = '0;
  logic [TMR_W-1:0] cfg_interval = 16'd20;
  logic short_word = 1'b0;
  logic pd_req = 1'b0;
  logic din_a = 1'b0;
  logic din_b = 1'b0;
  logic sclk, cs_n, res_valid, overrun;
  logic [DATA_W-1:0] res_a, res_b;

  dual_adc_reader #(.DIV_W(DIV_W), .TMR_W(TMR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .enable(enable), .cfg_div(cfg_div),
    .cfg_interval(cfg_interval), .short_word(short_word), .pd_req(pd_req),
    .din_a(din_a), .din_b(din_b), .sclk(sclk), .cs_n(cs_n),
    .res_a(res_a), .res_b(res_b), .res_valid(res_valid), .overrun(overrun)
  );

  always #2 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int compared = 0;
  int mismatched = 0;

  // converter model and event monitor
  logic [15:0] wa = '0, wb = '0;
  int exp_len = 16;
  int idx = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1;
  int frames_started = 0, frames_done = 0, valid_cnt = 0, idle_bad = 0;
  int start_cyc = 0, last_start = 0, gap = 0, fall_cnt = 0, first_delay = 0;
  int last_falls = 0, last_low = 0;
  logic last_valid = 1'b0;
  logic [15:0] last_ra = '0, last_rb = '0;

  always @(negedge clk) begin
    if (!rst) begin
      if (prev_cs && !cs_n) begin
        frames_started++;
        gap = cyc - last_start;
        last_start = cyc;
        start_cyc = cyc;
        fall_cnt = 0;
        idx = exp_len - 1;
        din_a = wa[idx];
        din_b = wb[idx];
      end
      if (!cs_n && prev_sclk && !sclk) begin
        fall_cnt++;
        if (fall_cnt == 1) first_delay = cyc - start_cyc;
        idx--;
        if (idx >= 0) begin
          din_a = wa[idx];
          din_b = wb[idx];
        end else begin
          din_a = 1'b0;
          din_b = 1'b0;
        end
      end
      if (!prev_cs && cs_n) begin
        frames_done++;
        last_falls = fall_cnt;
        last_low = cyc - start_cyc;
        last_valid = res_valid;
        last_ra = res_a;
        last_rb = res_b;
      end
      if (res_valid) valid_cnt++;
      if (cs_n && !sclk) idle_bad++;
    end
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    enable = 1'b0;
    pd_req = 1'b0;
    repeat (4) @(negedge clk);
    frames_started = 0; frames_done = 0; valid_cnt = 0; last_start = 0;
    rst = 1'b0;
  endtask

  task automatic configure(input int div, input int intv, input logic sh,
                           input logic [15:0] a, input logic [15:0] b);
    cfg_div = DIV_W'(div);
    cfg_interval = TMR_W'(intv);
    short_word = sh;
    wa = a;
    wb = b;
    exp_len = sh ? 14 : 16;
    do_reset();
  endtask

  task automatic t_reset_state();
    configure(3, 20, 1'b0, 16'h0, 16'h0);
    @(negedge clk);
    chk("R1 cs_n idle", int'(cs_n), 1);
    chk("R1 sclk idle", int'(sclk), 1);
    chk("R1 res_a", int'(res_a), 0);
    chk("R1 res_b", int'(res_b), 0);
    chk("R1 res_valid", int'(res_valid), 0);
    chk("R1 overrun", int'(overrun), 0);
    repeat (50) @(negedge clk);
    chk("R1 no frame while disabled", frames_started, 0);
  endtask

  task automatic t_full(input int div, input int intv, input logic [15:0] a, input logic [15:0] b);
    int p;
    p = 2 * (div + 1);
    configure(div, intv, 1'b0, a, b);
    enable = 1'b1;
    wait (frames_done >= 3);
    @(negedge clk);
    chk("R6 lane A word", int'(last_ra), int'(a));
    chk("R6 lane B word", int'(last_rb), int'(b));
    chk("R7 strobe at close", int'(last_valid), 1);
    chk("R7 one strobe per frame", valid_cnt, frames_done);
    chk("R4 falling edges", last_falls, 16);
    chk("R4 select low time", last_low, 16 * p);
    chk("R2 first fall delay", first_delay, div + 1);
    chk("R3 start spacing", gap, intv * p);
    chk("R9 no overrun", int'(overrun), 0);
    chk("R1 sclk high between frames", idle_bad, 0);
    enable = 1'b0;
  endtask

  task automatic t_short();
    int p;
    p = 4;
    configure(1, 20, 1'b1, 16'hFFFF, 16'h8001);
    enable = 1'b1;
    wait (frames_done >= 2);
    @(negedge clk);
    chk("R5 falling edges", last_falls, 14);
    chk("R5 select low time", last_low, 14 * p);
    chk("R6 short lane A right-justified", int'(last_ra), 16'h3FFF);
    chk("R6 short lane B right-justified", int'(last_rb), 16'h0001);
    enable = 1'b0;
  endtask

  task automatic t_powerdown();
    int p, vbase;
    logic [15:0] ra0, rb0;
    p = 6;
    configure(2, 24, 1'b0, 16'h1234, 16'hFEDC);
    enable = 1'b1;
    wait (frames_done >= 1);
    @(negedge clk);
    vbase = valid_cnt;
    ra0 = res_a;
    rb0 = res_b;
    exp_len = 8;
    wa = 16'h00FF;
    wb = 16'h00AA;
    pd_req = 1'b1;
    @(negedge clk);
    pd_req = 1'b0;
    wait (frames_done >= 2);
    @(negedge clk);
    chk("R8 burst falling edges", last_falls, 8);
    chk("R8 burst select low time", last_low, 8 * p);
    chk("R8 no strobe in burst", valid_cnt, vbase);
    chk("R8 lane A held", int'(res_a), int'(ra0));
    chk("R8 lane B held", int'(res_b), int'(rb0));
    exp_len = 16;
    wa = 16'h5A5A;
    wb = 16'h0F0F;
    wait (frames_done >= 3);
    @(negedge clk);
    chk("R8 normal after burst edges", last_falls, 16);
    chk("R8 normal after burst data", int'(last_ra), 16'h5A5A);
    chk("R8 normal after burst strobe", int'(last_valid), 1);
    enable = 1'b0;
  endtask

  task automatic t_overrun();
    configure(0, 17, 1'b0, 16'hC3A5, 16'h7E81);
    enable = 1'b1;
    wait (frames_done >= 3);
    @(negedge clk);
    chk("R9 overrun set", int'(overrun), 1);
    chk("R9 dropped tick spacing", gap, 34 * 2);
    chk("R9 data still right", int'(last_ra), 16'hC3A5);
    enable = 1'b0;
    repeat (40) @(negedge clk);
    chk("R9 overrun sticky", int'(overrun), 1);
    configure(0, 18, 1'b0, 16'hC3A5, 16'h7E81);
    enable = 1'b1;
    wait (frames_done >= 3);
    @(negedge clk);
    chk("R9 no overrun at margin", int'(overrun), 0);
    chk("R3 spacing at margin", gap, 18 * 2);
    enable = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    t_reset_state();
    t_full(3, 20, 16'hA5C3, 16'h3C5A);
    t_full(0, 18, 16'hFFFF, 16'h0001);
    t_full(1, 25, 16'h8000, 16'h6DB6);
    t_short();
    t_powerdown();
    t_overrun();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule